// File: doc/BRIEF.md
# Pipeline Trap and Interrupt Control Unit

This unit decides, once per cycle, whether the instruction now at the memory stage of a five-stage pipeline must be abandoned for an interrupt or an instruction exception. It also handles the return from a handler. It keeps three coprocessor registers: a status word with the enables and an exception-level bit, a cause word with the trap code and a branch-delay marker, and a saved return address. These registers are read and written through a simple register-number port that serves the move-to and move-from coprocessor instructions.

When a trap is taken, the unit asserts a redirect to the fixed handler entry 0x4180 and a flush of the younger stages, and it records where execution must resume. If the stage holds a store in that cycle, the unit also kills that store's memory write. A return instruction redirects fetch to the saved address and flushes the following slot, because a return has no delay slot. That flush is held off while the pipeline is stalled.

Top module: `trap_ctrl_unit`

## Requirements
- R1: After reset, the register read port returns 0 for register numbers 12 (status), 13 (cause) and 14 (return address). Any other register number always reads 0.
- R2: A write through the register port becomes visible at the next clock edge; in the write cycle the read still returns the old value. Only status bits 0, 1 and 12 can be written, and the other status bits read 0. The return address takes all 32 bits. Writes to the cause register are ignored.
- R3: An external interrupt is taken only when status bit 0 (global enable) and status bit 12 (line mask) are both 1 and status bit 1 (exception level) is 0. When it is taken, redirect_valid=1, redirect_pc=0x4180 and flush_req=1 in the same cycle.
- R4: On a trap at a stage that is not a delay slot, the return address becomes the stage PC with bits 1:0 cleared, and cause bit 31 becomes 0. For an interrupt, cause bits 6:2 become 0.
- R5: On a trap at a delay-slot stage, the return address becomes the word-aligned stage PC minus 4, and cause bit 31 becomes 1.
- R6: A nonzero exception code is taken whatever the status bits are. It redirects to 0x4180 with a flush, and cause bits 6:2 take the code.
- R7: When an enabled interrupt and a nonzero exception code arrive in the same cycle, the interrupt wins and cause bits 6:2 become 0.
- R8: Taking a trap sets status bit 1. While that bit is set, the external interrupt is not taken.
- R9: store_kill is 1 exactly when a trap is taken in a cycle where the stage holds a store; otherwise it is 0.
- R10: A return with no trap and no stall gives redirect_valid=1, redirect_pc equal to the saved return address, and flush_req=1. It clears status bit 1 at the next edge.
- R11: A return while stall is high gives no redirect and no flush, and leaves status unchanged.
- R12: A register-port write in the same cycle as a taken trap or an acted-on return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stg_pc | input | 32 | PC of the instruction at the memory stage |
| stg_in_slot | input | 1 | Stage instruction sits in a branch delay slot |
| stg_exc_code | input | 5 | Pending exception code, 0 = none |
| ext_irq | input | 1 | External interrupt line |
| stg_is_ret | input | 1 | Stage instruction is a return from handler |
| stg_is_store | input | 1 | Stage instruction is a store |
| pipe_stall | input | 1 | Pipeline stall from the hazard logic |
| cp_sel | input | 5 | Coprocessor register number |
| cp_wdata | input | 32 | Coprocessor write data |
| cp_we | input | 1 | Coprocessor write enable |
| cp_rdata | output | 32 | Coprocessor read data |
| redirect_valid | output | 1 | Fetch redirect request |
| redirect_pc | output | 32 | Redirect target |
| ret_addr | output | 32 | Saved return address |
| flush_req | output | 1 | Flush younger stages |
| store_kill | output | 1 | Suppress the stage store's write |

## Verification
The trap decision is tried with the interrupt line under every partial enable setting, under a set exception level, and alone or together with an exception code. This tells apart a missing mask term from a wrong priority. Traps are placed at plain and delay-slot stages, and with and without a store, which separates the return-address and branch-delay logic from the store-kill path. Returns are issued with and without a stall, and register-port writes collide with traps and returns, which shows whether the update priorities in the register file are kept.

// File: rtl/trap_ctrl_pkg.sv
package trap_ctrl_pkg;
  localparam int unsigned SEL_W   = 5;
  localparam int unsigned CODE_W  = 5;
  localparam logic [SEL_W-1:0] REG_STATUS = 5'd12;
  localparam logic [SEL_W-1:0] REG_CAUSE  = 5'd13;
  localparam logic [SEL_W-1:0] REG_RET    = 5'd14;
  localparam int unsigned ST_IE   = 0;
  localparam int unsigned ST_EXL  = 1;
  localparam int unsigned ST_IM   = 12;
  localparam int unsigned CA_BD   = 31;
  localparam int unsigned CA_CODE = 2;

  typedef struct packed {
    logic take;    // trap entry this cycle
    logic is_irq;  // entry caused by the external line
    logic ret;     // return acted on this cycle
    logic cp_ok;   // register-port write allowed
  } trap_dec_t;
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] HANDLER_PC = 32'h0000_4180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_irq,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              is_ret,
  input  logic              is_store,
  input  logic              stall,
  input  logic              st_ie,
  input  logic              st_im,
  input  logic              st_exl,
  input  logic [DATA_W-1:0] ret_q,
  output trap_dec_t         dec,
  output logic              redirect_valid,
  output logic [DATA_W-1:0] redirect_pc,
  output logic              flush_req,
  output logic              store_kill
);
  logic irq_go, exc_go;

  always_comb begin
    irq_go          = ext_irq & st_ie & st_im & ~st_exl;
    exc_go          = |exc_code;
    dec.take        = irq_go | exc_go;
    dec.is_irq      = irq_go;
    dec.ret         = is_ret & ~dec.take & ~stall;
    dec.cp_ok       = ~dec.take & ~dec.ret;
    redirect_valid  = dec.take | dec.ret;
    redirect_pc     = dec.take ? HANDLER_PC : ret_q;
    flush_req       = dec.take | dec.ret;
    store_kill      = dec.take & is_store;
  end

  // Exception level blocks the line when no code is pending
  assert_exl_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_exl && exc_code == '0) |-> !dec.take);

  // A stalled return never flushes the next slot
  assert_stall_over_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && is_ret && !dec.take) |-> (!flush_req && !redirect_valid));
endmodule

// File: rtl/trap_cp_regs.sv
module trap_cp_regs
  import trap_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] STATUS_WMASK = 32'h0000_1003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pc,
  input  logic              in_slot,
  input  logic [CODE_W-1:0] exc_code,
  input  trap_dec_t         dec,
  input  logic [SEL_W-1:0]  cp_sel,
  input  logic [DATA_W-1:0] cp_wdata,
  input  logic              cp_we,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] ret_q,
  output logic [DATA_W-1:0] cp_rdata
);
  localparam logic [DATA_W-1:0] ALIGN_MASK = {{(DATA_W-2){1'b1}}, 2'b00};
  localparam logic [DATA_W-1:0] WORD_BYTES = DATA_W'(4);

  logic [DATA_W-1:0] status_d, ret_d, status_wr, pc_al, ret_tgt, cause_rd;
  logic              bd_q, bd_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              st_en, ret_en, ca_en, cp_go;

  for (genvar b = 0; b < DATA_W; b++) begin : g_stmask
    if (STATUS_WMASK[b]) begin : g_wr
      assign status_wr[b] = cp_wdata[b];
    end else begin : g_ro
      assign status_wr[b] = 1'b0;
    end
  end

  always_comb begin
    pc_al    = pc & ALIGN_MASK;
    ret_tgt  = in_slot ? (pc_al - WORD_BYTES) : pc_al;
    cp_go    = cp_we & dec.cp_ok;
    status_d = status_q;
    ret_d    = ret_q;
    bd_d     = bd_q;
    code_d   = code_q;
    if (dec.take) begin
      status_d[ST_EXL] = 1'b1;
      ret_d            = ret_tgt;
      bd_d             = in_slot;
      code_d           = dec.is_irq ? '0 : exc_code;
    end else if (dec.ret) begin
      status_d[ST_EXL] = 1'b0;
    end else if (cp_go && cp_sel == REG_STATUS) begin
      status_d = status_wr;
    end else if (cp_go && cp_sel == REG_RET) begin
      ret_d = cp_wdata;
    end
    st_en  = dec.take | dec.ret | (cp_go & (cp_sel == REG_STATUS));
    ret_en = dec.take | (cp_go & (cp_sel == REG_RET));
    ca_en  = dec.take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      ret_q    <= '0;
      bd_q     <= 1'b0;
      code_q   <= '0;
    end else begin
      if (st_en)  status_q <= status_d;
      if (ret_en) ret_q    <= ret_d;
      if (ca_en) begin
        bd_q   <= bd_d;
        code_q <= code_d;
      end
    end
  end

  always_comb begin
    cause_rd = '0;
    cause_rd[CA_BD] = bd_q;
    cause_rd[CA_CODE +: CODE_W] = code_q;
    case (cp_sel)
      REG_STATUS: cp_rdata = status_q;
      REG_CAUSE:  cp_rdata = cause_rd;
      REG_RET:    cp_rdata = ret_q;
      default:    cp_rdata = '0;
    endcase
  end

  assert_entry_sets_exl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec.take |=> status_q[ST_EXL]);

  assert_slot_backs_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.take && in_slot) |=> (bd_q && ret_q == (($past(pc) & ALIGN_MASK) - WORD_BYTES)));

  assert_irq_code_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.take && dec.is_irq) |=> (code_q == '0));

  assert_ret_clears_exl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dec.ret |=> !status_q[ST_EXL]);

  assert_cause_readonly_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dec.take |=> $stable(code_q) && $stable(bd_q));
endmodule

// File: rtl/trap_ctrl_unit.sv
module trap_ctrl_unit
  import trap_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] HANDLER_PC   = 32'h0000_4180,
  parameter logic [DATA_W-1:0] STATUS_WMASK = 32'h0000_1003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] stg_pc,
  input  logic              stg_in_slot,
  input  logic [CODE_W-1:0] stg_exc_code,
  input  logic              ext_irq,
  input  logic              stg_is_ret,
  input  logic              stg_is_store,
  input  logic              pipe_stall,
  input  logic [SEL_W-1:0]  cp_sel,
  input  logic [DATA_W-1:0] cp_wdata,
  input  logic              cp_we,
  output logic [DATA_W-1:0] cp_rdata,
  output logic              redirect_valid,
  output logic [DATA_W-1:0] redirect_pc,
  output logic [DATA_W-1:0] ret_addr,
  output logic              flush_req,
  output logic              store_kill
);
  trap_dec_t         dec;
  logic [DATA_W-1:0] status_q, ret_q;

  trap_arbiter #(.DATA_W(DATA_W), .HANDLER_PC(HANDLER_PC)) u_arb (
    .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .exc_code(stg_exc_code),
    .is_ret(stg_is_ret), .is_store(stg_is_store), .stall(pipe_stall),
    .st_ie(status_q[ST_IE]), .st_im(status_q[ST_IM]), .st_exl(status_q[ST_EXL]),
    .ret_q(ret_q), .dec(dec), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .flush_req(flush_req), .store_kill(store_kill)
  );

  trap_cp_regs #(.DATA_W(DATA_W), .STATUS_WMASK(STATUS_WMASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .pc(stg_pc), .in_slot(stg_in_slot),
    .exc_code(stg_exc_code), .dec(dec), .cp_sel(cp_sel), .cp_wdata(cp_wdata),
    .cp_we(cp_we), .status_q(status_q), .ret_q(ret_q), .cp_rdata(cp_rdata)
  );

  assign ret_addr = ret_q;

  assert_store_kill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    store_kill |-> (flush_req && stg_is_store && redirect_pc == HANDLER_PC));

  assert_trap_redirect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_irq && status_q[ST_IE] && status_q[ST_IM] && !status_q[ST_EXL])
      |-> (redirect_valid && flush_req && redirect_pc == HANDLER_PC));
endmodule

// File: tb/tb_trap_ctrl_unit.sv
`timescale 1ns/1ps
module tb_trap_ctrl_unit;
  logic        clk, rst_n;
  logic [31:0] stg_pc, cp_wdata, cp_rdata, redirect_pc, ret_addr;
  logic        stg_in_slot, ext_irq, stg_is_ret, stg_is_store, pipe_stall, cp_we;
  logic [4:0]  stg_exc_code, cp_sel;
  logic        redirect_valid, flush_req, store_kill;
  int          nchk, nfail;
  logic        done;
  logic [31:0] v;

  localparam logic [31:0] HND = 32'h0000_4180;

  trap_ctrl_unit dut (
    .clk(clk), .rst_n(rst_n), .stg_pc(stg_pc), .stg_in_slot(stg_in_slot),
    .stg_exc_code(stg_exc_code), .ext_irq(ext_irq), .stg_is_ret(stg_is_ret),
    .stg_is_store(stg_is_store), .pipe_stall(pipe_stall), .cp_sel(cp_sel),
    .cp_wdata(cp_wdata), .cp_we(cp_we), .cp_rdata(cp_rdata),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .ret_addr(ret_addr), .flush_req(flush_req), .store_kill(store_kill)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    stg_pc = 32'h3000; stg_in_slot = 0; stg_exc_code = 0; ext_irq = 0;
    stg_is_ret = 0; stg_is_store = 0; pipe_stall = 0;
    cp_sel = 0; cp_wdata = 0; cp_we = 0;
  endtask

  task automatic rd(input logic [4:0] s, output logic [31:0] val);
    @(negedge clk); idle(); cp_sel = s; #1 val = cp_rdata;
  endtask

  task automatic wr(input logic [4:0] s, input logic [31:0] d);
    @(negedge clk); idle(); cp_sel = s; cp_wdata = d; cp_we = 1; #1;
  endtask

  task automatic fire(input logic [31:0] pc, input logic slot, input logic [4:0] code,
                      input logic irq, input logic ret, input logic st, input logic stall);
    @(negedge clk); idle();
    stg_pc = pc; stg_in_slot = slot; stg_exc_code = code; ext_irq = irq;
    stg_is_ret = ret; stg_is_store = st; pipe_stall = stall; #1;
  endtask

  task automatic t_reset();
    rd(5'd12, v); chk("R1 status", v, 0);
    rd(5'd13, v); chk("R1 cause", v, 0);
    rd(5'd14, v); chk("R1 retaddr", v, 0);
    rd(5'd7, v);  chk("R1 other reg", v, 0);
    chk("R1 no redirect", {31'b0, redirect_valid}, 0);
  endtask

  task automatic t_regs();
    wr(5'd14, 32'h1234_5678); chk("R2 old value in write cycle", cp_rdata, 0);
    rd(5'd14, v); chk("R2 retaddr write", v, 32'h1234_5678);
    wr(5'd13, 32'hFFFF_FFFF);
    rd(5'd13, v); chk("R2 cause ignores write", v, 0);
    wr(5'd12, 32'hFFFF_FFFF);
    rd(5'd12, v); chk("R2 status mask", v, 32'h0000_1003);
    wr(5'd12, 32'h0);
  endtask

  task automatic t_irq();
    wr(5'd12, 32'h0000_0001);
    fire(32'h3016, 0, 0, 1, 0, 0, 0); chk("R3 mask bit off", {31'b0, redirect_valid}, 0);
    wr(5'd12, 32'h0000_1000);
    fire(32'h3016, 0, 0, 1, 0, 0, 0); chk("R3 global off", {31'b0, redirect_valid}, 0);
    wr(5'd12, 32'h0000_1001);
    fire(32'h3016, 0, 0, 1, 0, 0, 0);
    chk("R3 redirect", {31'b0, redirect_valid}, 1);
    chk("R3 handler", redirect_pc, HND);
    chk("R3 flush", {31'b0, flush_req}, 1);
    chk("R9 no store", {31'b0, store_kill}, 0);
    rd(5'd14, v); chk("R4 retaddr aligned", v, 32'h3014);
    rd(5'd13, v); chk("R4 cause", v, 0);
    rd(5'd12, v); chk("R8 exl set", v, 32'h0000_1003);
    fire(32'h4184, 0, 0, 1, 0, 0, 0); chk("R8 masked by exl", {31'b0, redirect_valid}, 0);
    fire(32'h41a0, 0, 0, 0, 1, 0, 0);
    chk("R10 ret redirect", {31'b0, redirect_valid}, 1);
    chk("R10 ret target", redirect_pc, 32'h3014);
    chk("R10 ret flush", {31'b0, flush_req}, 1);
    rd(5'd12, v); chk("R10 exl cleared", v, 32'h0000_1001);
  endtask

  task automatic t_slot();
    fire(32'h3034, 1, 0, 1, 0, 0, 0); chk("R5 redirect", {31'b0, redirect_valid}, 1);
    rd(5'd14, v); chk("R5 retaddr minus 4", v, 32'h3030);
    rd(5'd13, v); chk("R5 bd bit", v, 32'h8000_0000);
    fire(32'h41a0, 0, 0, 0, 1, 0, 0); chk("R5 ret to branch", redirect_pc, 32'h3030);
  endtask

  task automatic t_store();
    fire(32'h3020, 0, 0, 0, 0, 1, 0); chk("R9 store no trap", {31'b0, store_kill}, 0);
    fire(32'h3020, 0, 0, 1, 0, 1, 0); chk("R9 store killed", {31'b0, store_kill}, 1);
    fire(32'h41a0, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_exc();
    wr(5'd12, 32'h0);
    fire(32'h3074, 0, 5'd5, 0, 0, 0, 0);
    chk("R6 exc redirect", {31'b0, redirect_valid}, 1);
    chk("R6 exc handler", redirect_pc, HND);
    rd(5'd13, v); chk("R6 cause code", v, 32'h0000_0014);
    rd(5'd14, v); chk("R6 retaddr", v, 32'h3074);
    fire(32'h41a0, 0, 0, 0, 1, 0, 0);
    fire(32'h307c, 1, 5'd5, 0, 0, 0, 0);
    rd(5'd13, v); chk("R6 slot cause", v, 32'h8000_0014);
    rd(5'd14, v); chk("R5 slot exc retaddr", v, 32'h3078);
    fire(32'h41a0, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_both();
    wr(5'd12, 32'h0000_1001);
    fire(32'h3044, 0, 5'd4, 1, 0, 0, 0); chk("R7 redirect", {31'b0, redirect_valid}, 1);
    rd(5'd13, v); chk("R7 irq wins code 0", v, 0);
    fire(32'h41a0, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_stall();
    fire(32'h3060, 0, 0, 1, 0, 0, 0);
    fire(32'h41a0, 0, 0, 0, 1, 0, 1);
    chk("R11 no flush", {31'b0, flush_req}, 0);
    chk("R11 no redirect", {31'b0, redirect_valid}, 0);
    rd(5'd12, v); chk("R11 status held", v, 32'h0000_1003);
    fire(32'h41a0, 0, 0, 0, 1, 0, 0);
    chk("R11 flush after stall", {31'b0, flush_req}, 1);
    chk("R11 target", redirect_pc, 32'h3060);
    rd(5'd12, v); chk("R10 exl cleared later", v, 32'h0000_1001);
  endtask

  task automatic t_conflict();
    fire(32'h306c, 0, 0, 1, 0, 0, 0);
    cp_sel = 5'd14; cp_wdata = 32'hDEAD_0000; cp_we = 1;
    rd(5'd14, v); chk("R12 trap beats write", v, 32'h306c);
    fire(32'h41a0, 0, 0, 0, 1, 0, 0);
    cp_sel = 5'd12; cp_wdata = 32'h0; cp_we = 1;
    rd(5'd12, v); chk("R12 ret beats write", v, 32'h0000_1001);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    nchk = 0; nfail = 0; done = 0;
    idle(); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_irq();
    t_slot();
    t_store();
    t_exc();
    t_both();
    t_stall();
    t_conflict();
    @(negedge clk); idle();
    summary();
  end
endmodule